// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an address seen on the PCI side into a host memory address for DMA. Four programmable windows are held in the block, each described by a base word, a mask word and a translated-base word. On a start pulse the incoming bus address is compared against every enabled window. The lowest-numbered hit either maps the address directly onto its translated base, or, for scatter-gather windows, reads one 64-bit page-table entry over a simple request/response memory port and builds the final address from that entry. An address that no enabled window claims comes out unchanged.

Control sits in a four-state machine. `ST_IDLE` waits for `start`. The transition *accept-direct* (start with no hit, or with a direct hit) goes to `ST_DONE`. The transition *accept-sg* (start with a scatter-gather hit) goes to `ST_SG_REQ`, which drives the single-cycle memory request and always moves on to `ST_SG_WAIT`. `ST_SG_WAIT` stays put until *response-seen* (`mem_rsp_valid` high), then goes to `ST_DONE`. `ST_DONE` shows the result with `done` high for one cycle and returns to `ST_IDLE` by *retire*.

Top module: `dma_window_xlat`

## Requirements
- R1: After reset every window word reads as zero, so all windows are disabled, and `done` and `mem_req_valid` are low.
- R2: A CSR write with `csr_we` high stores `csr_wdata` into window `csr_win` at the word picked by `csr_sel` (0 = base, 1 = mask, 2 = translated base). `csr_rdata` combinationally returns the word picked by `csr_win` and `csr_sel`, and returns zero for `csr_sel` = 3.
- R3: A window hits when base bit 0 (enable) is set and the bus address equals the base on every bit in 31:20 where the mask word is zero. Bits outside 31:20 never take part in the compare, and a disabled window never hits.
- R4: When several windows hit, the one with the lowest index is used.
- R5: With base bit 1 clear (direct), the pass field P is mask bits 31:20 plus bits 19:0; the result is the translated base with the P bits cleared, ORed with the bus address restricted to P.
- R6: When no window hits, the result equals the bus address, all 64 bits.
- R7: With base bit 1 set (scatter-gather), the block drives `mem_req_valid` for exactly one cycle with `mem_req_addr` = (translated base with bits clear where ((mask bits 31:20) >> 10 OR 0x3FF) is set) OR ((bus address AND (mask bits 31:20 OR bits 19:13)) >> 10). This address is always 8-byte aligned.
- R8: In scatter-gather mode the result is (entry with bit 0 cleared) shifted left by 12, ORed with bus address bits 12:0.
- R9: For direct and pass-through cases `done` is high in the cycle after the start cycle. For scatter-gather, `mem_req_valid` is high in the cycle after start; a response is taken no earlier than the following cycle, and `done` is high in the cycle after the response is taken. `done` lasts one cycle and `dma_addr` holds the result while it is high.
- R10: `start` is ignored while a translation is in progress (any state but idle); it produces no extra `done` and does not change the running result.
- R11: Window words are sampled in the start cycle: a CSR write in the same cycle as start, or while a scatter-gather read is pending, does not affect that translation, but it does affect the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| csr_we | input | 1 | Window word write strobe |
| csr_win | input | 2 | Window index for CSR write and read |
| csr_sel | input | 2 | Word select: 0 base, 1 mask, 2 translated base |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data for the selected word |
| start | input | 1 | Begin a translation of `bus_addr` |
| bus_addr | input | 64 | Incoming bus address |
| done | output | 1 | One-cycle result strobe |
| dma_addr | output | 64 | Translated address, valid with `done` |
| mem_req_valid | output | 1 | Page-table read request, one cycle |
| mem_req_addr | output | 64 | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table read response strobe |
| mem_rsp_data | input | 64 | Page-table entry returned |

## Verification
A CSR write and a translation start can share one clock edge, and a write can also land while a scatter-gather read is pending. The bench drives `start` and `csr_we` in the same cycle to disable the window that the started address hits, and expects the result computed from the old words, then a second translation that falls through to the next window. It also rewrites a scatter-gather window's translated base and pulses `start` with a different address while the memory response is held back. The judge is the scoreboard, which must see exactly one result, equal to the value predicted before the writes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W     = 64;
    localparam int PTE_SHIFT  = 10;
    localparam int PAGE_SHIFT = 12;
    localparam int EN_BIT     = 0;
    localparam int SG_BIT     = 1;

    // bits 31:20 take part in the window compare
    localparam logic [ADDR_W-1:0] CMP_FIELD   = 64'h0000_0000_FFF0_0000;
    // low bits always passed through in direct mode
    localparam logic [ADDR_W-1:0] DIRECT_LOW  = 64'h0000_0000_000F_FFFF;
    // page index bits used in scatter-gather mode
    localparam logic [ADDR_W-1:0] SG_IDX      = 64'h0000_0000_000F_E000;
    // low bits of the table base that are always replaced
    localparam logic [ADDR_W-1:0] SG_TBA_LOW  = 64'h0000_0000_0000_03FF;
    // byte offset inside a scatter-gather page
    localparam logic [ADDR_W-1:0] PAGE_OFF    = 64'h0000_0000_0000_1FFF;

    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_MASK  = 2'd1;
    localparam logic [1:0] SEL_TBASE = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SG_REQ,
        ST_SG_WAIT,
        ST_DONE
    } xlat_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] tbase;
    } win_regs_t;

endpackage

// File: rtl/xlat_csr.sv
module xlat_csr
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            csr_we,
    input  logic [IDX_W-1:0]                csr_win,
    input  logic [1:0]                      csr_sel,
    input  logic [ADDR_W-1:0]               csr_wdata,
    output logic [ADDR_W-1:0]               csr_rdata,
    output win_regs_t [NUM_WIN-1:0]         regs_o
);

    win_regs_t [NUM_WIN-1:0] regs_q;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic wr_hit;
        assign wr_hit = csr_we && (csr_win == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (wr_hit) begin
                unique case (csr_sel)
                    SEL_BASE:  regs_q[i].base  <= csr_wdata;
                    SEL_MASK:  regs_q[i].mask  <= csr_wdata;
                    SEL_TBASE: regs_q[i].tbase <= csr_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (csr_win == IDX_W'(i)) begin
                unique case (csr_sel)
                    SEL_BASE:  csr_rdata = regs_q[i].base;
                    SEL_MASK:  csr_rdata = regs_q[i].mask;
                    SEL_TBASE: csr_rdata = regs_q[i].tbase;
                    default:   csr_rdata = '0;
                endcase
            end
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/xlat_window.sv
module xlat_window
    import xlat_pkg::*;
(
    input  win_regs_t         regs,
    input  logic [ADDR_W-1:0] ba,
    output logic              hit,
    output logic              is_sg,
    output logic [ADDR_W-1:0] direct_addr,
    output logic [ADDR_W-1:0] pte_addr
);

    logic [ADDR_W-1:0] cmp_mask;
    logic [ADDR_W-1:0] mfield;
    logic [ADDR_W-1:0] pass_mask;
    logic [ADDR_W-1:0] idx_mask;
    logic [ADDR_W-1:0] tbl_keep;

    always_comb begin
        cmp_mask    = ~regs.mask & CMP_FIELD;
        hit         = regs.base[EN_BIT] && (((ba ^ regs.base) & cmp_mask) == '0);
        is_sg       = regs.base[SG_BIT];
        mfield      = regs.mask & CMP_FIELD;
        // direct mapping
        pass_mask   = mfield | DIRECT_LOW;
        direct_addr = (regs.tbase & ~pass_mask) | (ba & pass_mask);
        // page-table entry address
        idx_mask    = mfield | SG_IDX;
        tbl_keep    = ~((mfield >> PTE_SHIFT) | SG_TBA_LOW);
        pte_addr    = (regs.tbase & tbl_keep) | ((ba & idx_mask) >> PTE_SHIFT);
    end

endmodule

// File: rtl/xlat_select.sv
module xlat_select
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  win_regs_t [NUM_WIN-1:0] regs,
    input  logic [ADDR_W-1:0]       ba,
    output logic                    any_hit,
    output logic                    sel_sg,
    output logic [ADDR_W-1:0]       sel_direct,
    output logic [ADDR_W-1:0]       sel_pte
);

    logic [NUM_WIN-1:0]              w_hit;
    logic [NUM_WIN-1:0]              w_sg;
    logic [NUM_WIN-1:0][ADDR_W-1:0]  w_direct;
    logic [NUM_WIN-1:0][ADDR_W-1:0]  w_pte;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        xlat_window u_win (
            .regs        (regs[i]),
            .ba          (ba),
            .hit         (w_hit[i]),
            .is_sg       (w_sg[i]),
            .direct_addr (w_direct[i]),
            .pte_addr    (w_pte[i])
        );
    end

    // lowest index wins: scan from the top so lower hits overwrite
    always_comb begin
        any_hit    = 1'b0;
        sel_sg     = 1'b0;
        sel_direct = '0;
        sel_pte    = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (w_hit[i]) begin
                any_hit    = 1'b1;
                sel_sg     = w_sg[i];
                sel_direct = w_direct[i];
                sel_pte    = w_pte[i];
            end
        end
    end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              any_hit,
    input  logic              sel_sg,
    input  logic [ADDR_W-1:0] sel_direct,
    input  logic [ADDR_W-1:0] sel_pte,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output xlat_state_e       state
);

    xlat_state_e       st_q, st_d;
    logic [ADDR_W-1:0] ba_q;
    logic [ADDR_W-1:0] pte_q;
    logic [ADDR_W-1:0] res_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = (any_hit && sel_sg) ? ST_SG_REQ : ST_DONE;
            ST_SG_REQ:  st_d = ST_SG_WAIT;
            ST_SG_WAIT: if (mem_rsp_valid) st_d = ST_DONE;
            ST_DONE:    st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ba_q  <= '0;
            pte_q <= '0;
            res_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    ba_q  <= bus_addr;
                    pte_q <= sel_pte;
                    res_q <= any_hit ? sel_direct : bus_addr;
                end
                ST_SG_WAIT: if (mem_rsp_valid) begin
                    res_q <= ((mem_rsp_data & ~ADDR_W'(1)) << PAGE_SHIFT)
                           | (ba_q & PAGE_OFF);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done          = (st_q == ST_DONE);
        mem_req_valid = (st_q == ST_SG_REQ);
        mem_req_addr  = pte_q;
        dma_addr      = res_q;
        state         = st_q;
    end

endmodule

// File: rtl/dma_window_xlat.sv
module dma_window_xlat
    import xlat_pkg::*;
#(
    parameter  int NUM_WIN = 4,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [IDX_W-1:0]  csr_win,
    input  logic [1:0]        csr_sel,
    input  logic [63:0]       csr_wdata,
    output logic [63:0]       csr_rdata,
    input  logic              start,
    input  logic [63:0]       bus_addr,
    output logic              done,
    output logic [63:0]       dma_addr,
    output logic              mem_req_valid,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);

    win_regs_t [NUM_WIN-1:0] regs;
    logic                    any_hit;
    logic                    sel_sg;
    logic [ADDR_W-1:0]       sel_direct;
    logic [ADDR_W-1:0]       sel_pte;
    xlat_state_e             fsm_st;

    xlat_csr #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_win   (csr_win),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .regs_o    (regs)
    );

    xlat_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .regs       (regs),
        .ba         (bus_addr),
        .any_hit    (any_hit),
        .sel_sg     (sel_sg),
        .sel_direct (sel_direct),
        .sel_pte    (sel_pte)
    );

    xlat_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .bus_addr      (bus_addr),
        .any_hit       (any_hit),
        .sel_sg        (sel_sg),
        .sel_direct    (sel_direct),
        .sel_pte       (sel_pte),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .dma_addr      (dma_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .state         (fsm_st)
    );

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk
    import xlat_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        done,
    input logic        mem_req_valid,
    input logic [63:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input xlat_state_e st
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R7
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    // R9
    start_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start) |=> (done || mem_req_valid));

    // R9
    rsp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SG_WAIT && mem_rsp_valid) |=> done);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && start) |=> !done && !mem_req_valid);

endmodule

bind dma_window_xlat xlat_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .st            (fsm_st)
);

// File: tb/sim_dma_window_xlat.sv
module sim_dma_window_xlat;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_win = '0;
    logic [1:0]  csr_sel = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        start = 1'b0;
    logic [63:0] bus_addr = '0;
    logic        done;
    logic [63:0] dma_addr;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int tests = 0;
    int fails = 0;
    int mem_lat = 0;

    logic [63:0] sh_base [4];
    logic [63:0] sh_mask [4];
    logic [63:0] sh_tba  [4];

    logic [63:0] exp_q [$];
    logic [63:0] pte_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_window_xlat u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_win(csr_win),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .start(start), .bus_addr(bus_addr), .done(done), .dma_addr(dma_addr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---- reference model, from the requirements ----
    function automatic logic [63:0] fld(input logic [63:0] m);
        return m & 64'h0000_0000_FFF0_0000;
    endfunction

    function automatic int pick(input logic [63:0] ba);
        for (int i = 0; i < 4; i++) begin
            logic [63:0] cm;
            cm = ~sh_mask[i] & 64'h0000_0000_FFF0_0000;
            if (sh_base[i][0] && ((ba & cm) == (sh_base[i] & cm))) return i;
        end
        return -1;
    endfunction

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {~a[31:0], a[31:4], 4'h7};
    endfunction

    function automatic logic [63:0] pte_of(input int w, input logic [63:0] ba);
        logic [63:0] keep;
        keep = ~((fld(sh_mask[w]) >> 10) | 64'h3FF);
        return (sh_tba[w] & keep) | ((ba & (fld(sh_mask[w]) | 64'h000F_E000)) >> 10);
    endfunction

    // returns 1 when scatter-gather is expected
    function automatic bit predict(input logic [63:0] ba, output logic [63:0] res,
                                   output logic [63:0] pte);
        int w;
        logic [63:0] p;
        w = pick(ba);
        pte = '0;
        if (w < 0) begin
            res = ba;
            return 1'b0;
        end
        if (sh_base[w][1]) begin
            pte = pte_of(w, ba);
            res = ((mem_word(pte) & ~64'h1) << 12) | (ba & 64'h1FFF);
            return 1'b1;
        end
        p = fld(sh_mask[w]) | 64'h000F_FFFF;
        res = (sh_tba[w] & ~p) | (ba & p);
        return 1'b0;
    endfunction

    // ---- driver tasks ----
    task automatic csr_wr(input int w, input int s, input logic [63:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_win = 2'(w); csr_sel = 2'(s); csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
        if (s == 0) sh_base[w] = d;
        if (s == 1) sh_mask[w] = d;
        if (s == 2) sh_tba[w] = d;
    endtask

    task automatic csr_rd(input int w, input int s, input logic [63:0] exp, input string req);
        @(negedge clk);
        csr_win = 2'(w); csr_sel = 2'(s);
        #1;
        check(req, csr_rdata, exp);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic xlat(input logic [63:0] ba, input string req);
        logic [63:0] r, p;
        bit sg;
        sg = predict(ba, r, p);
        exp_q.push_back(r);
        if (sg) pte_q.push_back(p);
        @(negedge clk);
        start = 1'b1; bus_addr = ba;
        @(negedge clk);
        start = 1'b0;
        // R9 latency of the first response
        if (sg) check({req, " R9 req latency"}, 64'(mem_req_valid), 64'd1);
        else    check({req, " R9 done latency"}, 64'(done), 64'd1);
        wait_idle();
    endtask

    // ---- scoreboard monitor ----
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R10 unexpected done actual=%h expected=none", dma_addr);
                end else begin
                    check("R5/R6/R8 result", dma_addr, exp_q.pop_front());
                end
            end
        end
    end

    // ---- memory responder ----
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                logic [63:0] a;
                a = mem_req_addr;
                if (pte_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R7 unexpected request actual=%h expected=none", a);
                end else begin
                    check("R7 pte address", a, pte_q.pop_front());
                end
                @(negedge clk);
                repeat (mem_lat) @(negedge clk);
                mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0; mem_rsp_data = '0;
            end
        end
    end

    // ---- watchdog ----
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---- stimulus ----
    initial begin
        for (int i = 0; i < 4; i++) begin
            sh_base[i] = '0; sh_mask[i] = '0; sh_tba[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 done low", 64'(done), 64'd0);
        check("R1 req low", 64'(mem_req_valid), 64'd0);
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 3; s++)
                csr_rd(w, s, 64'd0, "R1 reset word");
        // R6 nothing enabled yet
        xlat(64'hDEAD_0000_1234_5678, "R6 after reset");

        // R2 program windows and read back
        csr_wr(0, 1, 64'h0000_0000_0FF0_0000);
        csr_wr(0, 2, 64'h0000_0001_0000_0000);
        csr_wr(0, 0, 64'h0000_0000_4000_0001);
        csr_wr(1, 1, 64'h0000_0000_0010_0000);
        csr_wr(1, 2, 64'h0000_0000_2000_0000);
        csr_wr(1, 0, 64'h0000_0000_8000_0003);
        csr_wr(2, 2, 64'h0000_0000_7700_0000);
        csr_wr(2, 0, 64'h0000_0000_C000_0000);
        csr_wr(3, 1, 64'h0000_0000_0FF0_0000);
        csr_wr(3, 2, 64'h0000_0002_0000_0000);
        csr_wr(3, 0, 64'h0000_0000_4000_0001);
        csr_rd(0, 1, 64'h0000_0000_0FF0_0000, "R2 mask readback");
        csr_rd(1, 0, 64'h0000_0000_8000_0003, "R2 base readback");
        csr_rd(3, 2, 64'h0000_0002_0000_0000, "R2 tbase readback");
        csr_rd(1, 3, 64'd0, "R2 select 3 reads zero");

        // R5 direct, R4 window 0 beats window 3
        xlat(64'h0000_0000_4123_4567, "R5 R4 direct");
        check("R4 model picks window 0", 64'(pick(64'h4123_4567)), 64'd0);
        // R3 upper bits ignored, masked bits ignored
        xlat(64'hABCD_0000_4FF0_0010, "R3 upper bits");
        xlat(64'h0000_0000_5000_0000, "R3 outside window");
        // R3 disabled window 2 does not hit
        xlat(64'h0000_0000_C000_1234, "R3 disabled");
        // R7 R8 scatter-gather, two latencies
        mem_lat = 0;
        xlat(64'h0000_0000_8012_3456, "R7 R8 sg fast");
        mem_lat = 3;
        xlat(64'h0000_0000_801F_FFF8, "R7 R8 sg slow");
        // R6 unmatched
        xlat(64'h0000_0000_2000_0000, "R6 unmatched");

        // R11 write in the same cycle as start disables window 0
        begin
            logic [63:0] r, p;
            void'(predict(64'h4000_0100, r, p));
            exp_q.push_back(r);
            @(negedge clk);
            start = 1'b1; bus_addr = 64'h4000_0100;
            csr_we = 1'b1; csr_win = 2'd0; csr_sel = 2'd0; csr_wdata = 64'h0;
            @(negedge clk);
            start = 1'b0; csr_we = 1'b0;
            sh_base[0] = 64'h0;
            check("R11 R9 same-cycle done", 64'(done), 64'd1);
            wait_idle();
        end
        xlat(64'h0000_0000_4000_0100, "R11 R4 next hits window 3");

        // R10 R11 start and write while a scatter-gather read is pending
        mem_lat = 4;
        begin
            logic [63:0] r, p;
            void'(predict(64'h8010_2345, r, p));
            exp_q.push_back(r);
            pte_q.push_back(p);
            @(negedge clk);
            start = 1'b1; bus_addr = 64'h8010_2345;
            @(negedge clk);
            bus_addr = 64'h4000_0000;
            csr_we = 1'b1; csr_win = 2'd1; csr_sel = 2'd2; csr_wdata = 64'h0000_0000_3000_0000;
            @(negedge clk);
            start = 1'b0; csr_we = 1'b0;
            sh_tba[1] = 64'h0000_0000_3000_0000;
            wait_idle();
            repeat (3) @(negedge clk);
            check("R10 no extra result", 64'(exp_q.size()), 64'd0);
        end
        mem_lat = 1;
        xlat(64'h0000_0000_8010_2345, "R11 new tbase applies");

        repeat (5) @(negedge clk);
        check("R7 no pending request", 64'(pte_q.size()), 64'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule